// File: doc/BRIEF.md
# Port Pin Controller with Pullup Gating

This block is a small register-mapped general purpose I/O port for up to eight pins. Three registers are reachable over a simple bus: an output latch, a direction register and a pullup-enable register. Each holds one bit per pin. The block combines these registers with per-pin ownership inputs from shared peripherals and analog functions. From them it drives four per-pin controls to the pad ring: the output value, the output enable, the input-buffer enable and the pullup enable. Software reads the data address to get the live pin level on input pins and the latch value on output pins.

The block has a two-level low-power input. In the light stop level, every register and pad control keeps its value, and the port wakes up exactly as it was. In the deep stop level, the port is wiped. All three registers return to zero and every pad control goes low until the mode returns to run. After that, the registers stay at zero until software writes them again. The external reset is asserted asynchronously and its release is synchronised to the clock. The port stays quiet until that release has passed through the synchroniser.

Top module: `gpio_port`

## Requirements
- R1: While reset is active, and until two clock edges after reset is released, all registers read 0 and pad_out, pad_oe, pad_ie and pad_pu are all 0.
- R2: Writes are accepted only in run mode (lp_mode = 2'b00). A write with bus_addr 1 sets the direction register and a write with bus_addr 2 sets the pullup-enable register, and the new values read back on the following cycle.
- R3: A pin with direction bit 0 is an input, so pad_oe is 0 for it. A pin with direction bit 1 is an output: pad_oe is 1 and pad_out equals its latch bit. This holds unless a peripheral or an analog function owns the pin.
- R4: A read at bus_addr 0 returns, for each pin, the latch bit if the pin is an output. If the pin is an input, it returns pin_in gated by the input-buffer enable.
- R5: A write at bus_addr 0 updates the latch even while a pin is an input. The latch value appears on pad_out once the pin becomes an output.
- R6: pad_pu is 1 only when the pullup-enable bit is 1 and all three of these are 0: the direction bit, periph_oe and analog_own.
- R7: When periph_oe is 1, pad_oe is 1 and pad_out follows periph_out, whatever the direction and latch bits hold.
- R8: When analog_own is 1, pad_oe, pad_ie, pad_pu and pad_out are 0 for that pin, and a data read returns 0 for that pin if it is an input.
- R9: In deep stop (lp_mode bit 1 set), all pad controls are 0 and all registers are 0 from the next clock edge. Writes are ignored. After the return to run mode, the registers read 0 until they are rewritten.
- R10: In light stop (lp_mode = 2'b01), the registers and pad controls keep their values and writes are ignored.
- R11: Register bits above the pin count read 0 and ignore writes, and bus_addr 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 latch, 1 direction, 2 pullup enable |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| lp_mode | input | 2 | 00 run, 01 light stop, 1x deep stop |
| pin_in | input | NPINS | Pad input level |
| periph_oe | input | NPINS | Peripheral drives the pin |
| periph_out | input | NPINS | Peripheral output value |
| analog_own | input | NPINS | Analog function owns the pin |
| pad_out | output | NPINS | Pad output value |
| pad_oe | output | NPINS | Pad output enable |
| pad_ie | output | NPINS | Pad input-buffer enable |
| pad_pu | output | NPINS | Pad pullup enable |

## Verification
The port is stepped through several configurations: all pins as inputs, all pins as outputs, a mix of the two, and the same mix with first a peripheral and then an analog function taking one pin each. Each step separates one gating term of the pullup and the output enable from the others. The mixed pin levels on the data readback show whether each pin takes the latch or the pad path. Writes attempted during light stop and deep stop, followed by readback after wake-up, show retention apart from wiping. A reference model compares all four pad vectors and the read data on every cycle.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int REG_W = 8;

  typedef enum logic [1:0] {
    LP_RUN   = 2'b00,
    LP_LIGHT = 2'b01,
    LP_DEEP  = 2'b10,
    LP_DEEP2 = 2'b11
  } lp_mode_e;

  typedef enum logic [1:0] {
    A_LATCH = 2'd0,
    A_DIR   = 2'd1,
    A_PUE   = 2'd2,
    A_NONE  = 2'd3
  } reg_addr_e;

  function automatic logic is_deep(input logic [1:0] m);
    return m[1];
  endfunction
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q, chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_pkg::*;
#(
  parameter int NPINS = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [REG_W-1:0] wdata,
  input  logic [1:0]       mode,
  output logic [NPINS-1:0] dat_q,
  output logic [NPINS-1:0] dir_q,
  output logic [NPINS-1:0] pue_q
);
  logic [NPINS-1:0] dat_d, dir_d, pue_d;
  logic             wipe, run_wr;

  assign wipe   = is_deep(mode);
  assign run_wr = wr_en && (mode == LP_RUN);

  always_comb begin
    dat_d = dat_q;
    dir_d = dir_q;
    pue_d = pue_q;
    if (wipe) begin
      dat_d = '0;
      dir_d = '0;
      pue_d = '0;
    end else if (run_wr) begin
      unique case (addr)
        A_LATCH: dat_d = wdata[NPINS-1:0];
        A_DIR:   dir_d = wdata[NPINS-1:0];
        A_PUE:   pue_d = wdata[NPINS-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q <= '0;
      dir_q <= '0;
      pue_q <= '0;
    end else begin
      dat_q <= dat_d;
      dir_q <= dir_d;
      pue_q <= pue_d;
    end
  end

  assert_deep_wipe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    is_deep(mode) |=> (dat_q == '0 && dir_q == '0 && pue_q == '0));

  assert_light_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == LP_LIGHT) |=> ($stable(dat_q) && $stable(dir_q) && $stable(pue_q)));

  assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && mode == LP_RUN && addr == A_DIR) |=> (dir_q == $past(wdata[NPINS-1:0])));
endmodule

// File: rtl/gpio_padctl.sv
module gpio_padctl #(
  parameter int NPINS = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             quiesce,
  input  logic [NPINS-1:0] dat,
  input  logic [NPINS-1:0] dir,
  input  logic [NPINS-1:0] pue,
  input  logic [NPINS-1:0] periph_oe,
  input  logic [NPINS-1:0] periph_out,
  input  logic [NPINS-1:0] analog_own,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] pad_ie,
  output logic [NPINS-1:0] pad_pu
);
  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic live, driven;
    always_comb begin
      live      = !quiesce && !analog_own[i];
      driven    = periph_oe[i] || dir[i];
      pad_oe[i] = live && driven;
      pad_ie[i] = live;
      pad_out[i] = live && (periph_oe[i] ? periph_out[i] : dat[i]);
      pad_pu[i] = live && pue[i] && !driven;
    end
  end

  assert_pu_yield_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & (periph_oe | dir | analog_own)) == '0);

  assert_analog_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe | pad_ie | pad_pu | pad_out) & analog_own) == '0);

  assert_periph_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((periph_oe & ~analog_own & ~pad_oe) == '0) || quiesce);
endmodule

// File: rtl/gpio_rdmux.sv
module gpio_rdmux
  import gpio_pkg::*;
#(
  parameter int NPINS = 5
) (
  input  logic [1:0]       addr,
  input  logic [NPINS-1:0] dat,
  input  logic [NPINS-1:0] dir,
  input  logic [NPINS-1:0] pue,
  input  logic [NPINS-1:0] pin_in,
  input  logic [NPINS-1:0] pad_ie,
  output logic [REG_W-1:0] rdata
);
  logic [NPINS-1:0] sel;

  always_comb begin
    unique case (addr)
      A_LATCH: sel = (dir & dat) | (~dir & pin_in & pad_ie);
      A_DIR:   sel = dir;
      A_PUE:   sel = pue;
      default: sel = '0;
    endcase
    rdata = '0;
    rdata[NPINS-1:0] = sel;
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int NPINS    = 5,
  parameter int SYNC_STG = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       bus_addr,
  input  logic             bus_wr,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  input  logic [1:0]       lp_mode,
  input  logic [NPINS-1:0] pin_in,
  input  logic [NPINS-1:0] periph_oe,
  input  logic [NPINS-1:0] periph_out,
  input  logic [NPINS-1:0] analog_own,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] pad_ie,
  output logic [NPINS-1:0] pad_pu
);
  logic             srst_n;
  logic             quiesce;
  logic [NPINS-1:0] dat_q, dir_q, pue_q;

  gpio_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  gpio_regfile #(.NPINS(NPINS)) u_regs (
    .clk(clk), .rst_n(srst_n), .wr_en(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .mode(lp_mode),
    .dat_q(dat_q), .dir_q(dir_q), .pue_q(pue_q)
  );

  assign quiesce = !srst_n || is_deep(lp_mode);

  gpio_padctl #(.NPINS(NPINS)) u_pad (
    .clk(clk), .rst_n(srst_n), .quiesce(quiesce),
    .dat(dat_q), .dir(dir_q), .pue(pue_q),
    .periph_oe(periph_oe), .periph_out(periph_out), .analog_own(analog_own),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_ie(pad_ie), .pad_pu(pad_pu)
  );

  gpio_rdmux #(.NPINS(NPINS)) u_rd (
    .addr(bus_addr), .dat(dat_q), .dir(dir_q), .pue(pue_q),
    .pin_in(pin_in), .pad_ie(pad_ie), .rdata(bus_rdata)
  );

  if (NPINS < REG_W) begin : g_rsv
    assert_reserved_zero_R11: assert property (@(posedge clk) disable iff (!srst_n)
      bus_rdata[REG_W-1:NPINS] == '0);
  end

  assert_deep_pads_R9: assert property (@(posedge clk) disable iff (!srst_n)
    is_deep(lp_mode) |-> (pad_oe == '0 && pad_ie == '0 && pad_pu == '0 && pad_out == '0));
endmodule

// File: tb/tb_gpio_port.sv
module tb_gpio_port;
  localparam int N = 5;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   bus_addr = '0;
  logic         bus_wr = 1'b0;
  logic [7:0]   bus_wdata = '0;
  logic [7:0]   bus_rdata;
  logic [1:0]   lp_mode = 2'b00;
  logic [N-1:0] pin_in = '0, periph_oe = '0, periph_out = '0, analog_own = '0;
  logic [N-1:0] pad_out, pad_oe, pad_ie, pad_pu;

  int checks = 0, errors = 0;
  bit mon_on = 1'b0;

  always #4 clk = ~clk;

  gpio_port #(.NPINS(N)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lp_mode(lp_mode),
    .pin_in(pin_in), .periph_oe(periph_oe), .periph_out(periph_out),
    .analog_own(analog_own), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_ie(pad_ie), .pad_pu(pad_pu)
  );

  // reference model state
  logic [N-1:0] m_dat = '0, m_dir = '0, m_pue = '0;
  int           m_rel = 0;  // edges since reset release

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rel = 0; m_dat = '0; m_dir = '0; m_pue = '0;
    end else begin
      if (m_rel < 2) begin
        m_dat = '0; m_dir = '0; m_pue = '0;
      end else if (lp_mode[1]) begin
        m_dat = '0; m_dir = '0; m_pue = '0;
      end else if (bus_wr && lp_mode == 2'b00) begin
        if (bus_addr == 2'd0) m_dat = bus_wdata[N-1:0];
        if (bus_addr == 2'd1) m_dir = bus_wdata[N-1:0];
        if (bus_addr == 2'd2) m_pue = bus_wdata[N-1:0];
      end
      if (m_rel < 2) m_rel++;
    end
  end

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) if (mon_on) begin
    logic [N-1:0] live, e_oe, e_out, e_pu, rd0;
    logic [7:0]   e_rd;
    live  = (m_rel < 2 || !rst_n || lp_mode[1]) ? '0 : ~analog_own;
    e_oe  = live & (periph_oe | m_dir);
    e_out = live & ((periph_oe & periph_out) | (~periph_oe & m_dat));
    e_pu  = live & m_pue & ~m_dir & ~periph_oe;
    rd0   = (m_dir & m_dat) | (~m_dir & pin_in & live);
    e_rd  = '0;
    case (bus_addr)
      2'd0: e_rd[N-1:0] = rd0;
      2'd1: e_rd[N-1:0] = m_dir;
      2'd2: e_rd[N-1:0] = m_pue;
      default: e_rd = '0;
    endcase
    check("model pad_oe R3/R7/R8", 8'(pad_oe), 8'(e_oe));
    check("model pad_out R5/R7", 8'(pad_out), 8'(e_out));
    check("model pad_ie R8/R9", 8'(pad_ie), 8'(live));
    check("model pad_pu R6", 8'(pad_pu), 8'(e_pu));
    check("model rdata R4/R11", bus_rdata, e_rd);
  end

  task automatic step(); @(posedge clk); #2; endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    step();
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    step();
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [1:0] a, logic [7:0] exp);
    bus_addr = a;
    @(negedge clk);
    check(tag, bus_rdata, exp);
    #2;
  endtask

  initial begin
    #(8 * 50000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) step();
    mon_on = 1'b1;
    @(negedge clk);
    check("R1 oe in reset", 8'(pad_oe), 8'h00);
    check("R1 ie in reset", 8'(pad_ie), 8'h00);
    rst_n = 1'b1;
    step();
    @(negedge clk);
    check("R1 ie after one edge", 8'(pad_ie), 8'h00);
    repeat (2) step();
    rd_chk("R1 dir reset", 2'd1, 8'h00);
    check("R1 ie released", 8'(pad_ie), 8'h1F);

    wr(2'd2, 8'h1F);
    rd_chk("R2 pue readback", 2'd2, 8'h1F);
    check("R6 pu on inputs", 8'(pad_pu), 8'h1F);

    pin_in = 5'h0A;
    wr(2'd0, 8'h15);
    rd_chk("R4 input read", 2'd0, 8'h0A);
    check("R3 oe inputs", 8'(pad_oe), 8'h00);

    wr(2'd1, 8'h1F);
    @(negedge clk);
    check("R5 latch shows", 8'(pad_out), 8'h15);
    check("R3 oe outputs", 8'(pad_oe), 8'h1F);
    check("R6 pu off outputs", 8'(pad_pu), 8'h00);
    #2;
    rd_chk("R4 output read", 2'd0, 8'h15);

    wr(2'd1, 8'h03);
    rd_chk("R4 mixed read", 2'd0, 8'h09);
    check("R6 pu mixed", 8'(pad_pu), 8'h1C);

    periph_oe = 5'h04; periph_out = 5'h00;
    @(negedge clk);
    check("R7 oe periph", 8'(pad_oe), 8'h07);
    check("R7 out periph", 8'(pad_out), 8'h11);
    check("R6 pu periph", 8'(pad_pu), 8'h18);
    #2;

    analog_own = 5'h10; pin_in = 5'h1A;
    @(negedge clk);
    check("R8 ie analog", 8'(pad_ie), 8'h0F);
    check("R8 pu analog", 8'(pad_pu), 8'h08);
    check("R8 out analog", 8'(pad_out), 8'h01);
    #2;
    rd_chk("R8 analog read", 2'd0, 8'h09);

    wr(2'd1, 8'hFF);
    rd_chk("R11 reserved dir", 2'd1, 8'h1F);
    rd_chk("R11 addr3", 2'd3, 8'h00);

    lp_mode = 2'b01;
    wr(2'd1, 8'h00);
    rd_chk("R10 light hold dir", 2'd1, 8'h1F);
    check("R10 light oe", 8'(pad_oe), 8'h0F);
    lp_mode = 2'b00;
    step();

    lp_mode = 2'b10;
    @(negedge clk);
    check("R9 deep oe", 8'(pad_oe), 8'h00);
    check("R9 deep ie", 8'(pad_ie), 8'h00);
    #2;
    wr(2'd2, 8'h1F);
    lp_mode = 2'b00;
    rd_chk("R9 dir wiped", 2'd1, 8'h00);
    rd_chk("R9 pue wiped", 2'd2, 8'h00);
    check("R9 ie back", 8'(pad_ie), 8'h0F);
    wr(2'd1, 8'h02);
    rd_chk("R2 rewrite dir", 2'd1, 8'h02);

    repeat (3) step();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule